// File: doc/BRIEF.md
# Companded PCM Attenuate-or-Silence Stage

This block sits at the end of a decoder path, just before the 8-bit companded PCM sample is shifted out. Once per frame a strobe hands it one sample byte together with a set of controls. A per-channel enable switches on post-processing. A shared behaviour select decides what the enable does. In silence behaviour the sample is replaced by the idle-channel code of the active law. In attenuate behaviour the sample loses about 12 dB: the byte is expanded to linear, shifted arithmetically right by two and compressed again with the same law. A law select picks A-law or µ-law coding. A through flag overrides everything and passes the byte unchanged.

The block is one small state machine with four states. S_IDLE waits for the frame strobe and latches the byte and all controls on the CAPTURE transition to S_EXPAND. S_EXPAND converts the byte to linear on the LINEARIZE transition to S_SCALE. S_SCALE applies the arithmetic shift on the ATTENUATE transition to S_EMIT. S_EMIT picks and registers the result, pulses the valid strobe, and takes the PUBLISH transition back to S_IDLE. Every accepted sample therefore takes the same number of cycles, whatever the mode.

Top module: `pcm_pad_mute`

## Requirements
- R1: While reset is asserted and after its release, `out_vld` is 0 and `pcm_out` is 8'h00 until the first result is published.
- R2: A `frame_stb` sampled high at a rising edge while the block is idle produces exactly one `out_vld` pulse, one cycle long, that starts right after the third rising edge that follows it; `pcm_out` is valid during that pulse.
- R3: A `frame_stb` sampled high in the three edges after an accepted strobe is ignored: it produces no extra pulse and does not replace the captured byte.
- R4: With `thru` at 0 and `atten_en` at 0, the result equals the input byte for every code and both laws.
- R5: With `thru` at 0, `atten_en` at 1 and `sel_pad` at 0, the result is the idle code: 8'hFF when `sel_alaw` is 0 (µ-law) and 8'hD5 when `sel_alaw` is 1 (A-law), whatever the input byte.
- R6: With `thru` 0, `atten_en` 1, `sel_pad` 1 and `sel_alaw` 0, the result is the µ-law code of (x >>> 2), where x is the µ-law value of the input byte. In µ-law, bit 7 set means positive. The low seven bits, inverted, give a segment s in bits 6:4 and a step m in bits 3:0, with magnitude ((2m+33)<<s)−33. Compression adds 33 to the magnitude and picks the largest code whose interval start is not above it.
- R7: With `thru` 0, `atten_en` 1, `sel_pad` 1 and `sel_alaw` 1, the result is the A-law code of (x >>> 2). The byte is first XORed with 8'h55. Bit 7 set then means positive, and bits 6:4 hold s while bits 3:0 hold m. The magnitude is 2m+1 for s=0 and (2m+33)<<(s−1) otherwise. Compression works on the magnitude for positive values and on −x−1 for negative ones, with interval starts 2m for s=0 and (16+m)<<s otherwise.
- R8: With `thru` at 1, the result equals the input byte regardless of `atten_en`, `sel_pad` and `sel_alaw`.
- R9: The byte and all controls are taken only at the accepted strobe edge. Changing any of them during the following three cycles has no effect on that result.
- R10: `pcm_out` changes only at the edge that raises `out_vld` and holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | Frame strobe that delivers one sample |
| pcm_in | input | 8 | Companded sample byte from the decoder |
| sel_pad | input | 1 | Shared behaviour select: 1 attenuate, 0 silence |
| sel_alaw | input | 1 | Law select: 1 A-law, 0 µ-law |
| atten_en | input | 1 | Per-channel enable of the selected behaviour |
| thru | input | 1 | Through flag, passes the byte untouched |
| pcm_out | output | 8 | Processed sample byte |
| out_vld | output | 1 | One-cycle strobe marking a new result |

## Verification
Every result is due right after the third rising edge that follows the accepting edge. The bench raises the strobe at a falling edge, waits for the accepting edge and three more, and samples `pcm_out` and `out_vld` at the next falling edge. At the following falling edge it confirms that the pulse has dropped. For R3 and R9 the bench changes the byte, the controls or the strobe in the cycles between acceptance and publication, then counts pulses over a further window. Expected bytes come from bench functions that decode by formula and encode by searching interval starts, not by segment arithmetic.

// File: rtl/pcm_pad_pkg.sv
package pcm_pad_pkg;

    localparam int BYTE_W = 8;
    localparam int LIN_W  = 14;
    localparam int SHIFT  = 2;

    localparam logic [BYTE_W-1:0] MU_IDLE = 8'hFF;
    localparam logic [BYTE_W-1:0] A_IDLE  = 8'hD5;
    localparam logic [BYTE_W-1:0] A_TOGGLE = 8'h55;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_EXPAND = 2'd1,
        S_SCALE  = 2'd2,
        S_EMIT   = 2'd3
    } stage_e;

    function automatic logic [BYTE_W-1:0] idle_code(input logic alaw);
        return alaw ? A_IDLE : MU_IDLE;
    endfunction

endpackage

// File: rtl/law_expander.sv
module law_expander
    import pcm_pad_pkg::*;
#(
    parameter int LW = LIN_W
) (
    input  logic [BYTE_W-1:0]    code_i,
    input  logic                 alaw_i,
    output logic signed [LW-1:0] lin_o
);
    localparam logic [LW-1:0] BIAS = LW'(33);
    localparam logic [LW-1:0] HALF = LW'(32);

    logic [BYTE_W-1:0] t;
    logic [2:0]        seg;
    logic [3:0]        mant;
    logic [LW-1:0]     step;
    logic [LW-1:0]     mag;

    always_comb begin
        t    = alaw_i ? (code_i ^ A_TOGGLE) : ~code_i;
        seg  = t[6:4];
        mant = t[3:0];
        step = LW'({mant, 1'b1});
        if (alaw_i) begin
            if (seg == 3'd0) mag = step;
            else             mag = (step + HALF) << (seg - 3'd1);
        end else begin
            mag = ((step + HALF) << seg) - BIAS;
        end
        lin_o = code_i[7] ? signed'(mag) : -signed'(mag);
    end

endmodule

// File: rtl/law_compressor.sv
module law_compressor
    import pcm_pad_pkg::*;
#(
    parameter int LW = LIN_W
) (
    input  logic signed [LW-1:0] lin_i,
    input  logic                 alaw_i,
    output logic [BYTE_W-1:0]    code_o
);
    localparam int EW = LW + 1;
    localparam logic [EW-1:0] MU_CLIP = EW'(8158);
    localparam logic [EW-1:0] A_CLIP  = EW'(4095);
    localparam logic [EW-1:0] BIAS    = EW'(33);

    logic              neg;
    logic signed [EW-1:0] ext;
    logic [EW-1:0]     mag;
    logic [EW-1:0]     val;
    logic [EW-1:0]     sh;
    int                top;
    logic [2:0]        seg;
    logic [3:0]        mant;

    always_comb begin
        neg = lin_i[LW-1];
        ext = {lin_i[LW-1], lin_i};
        if (alaw_i) mag = neg ? unsigned'(-ext - EW'(1)) : unsigned'(ext);
        else        mag = neg ? unsigned'(-ext)          : unsigned'(ext);
        if (alaw_i) val = (mag > A_CLIP)  ? A_CLIP : mag;
        else        val = ((mag > MU_CLIP) ? MU_CLIP : mag) + BIAS;
        top = 0;
        for (int i = 0; i < EW; i++) begin
            if (val[i]) top = i;
        end
        seg  = 3'd0;
        mant = 4'd0;
        sh   = '0;
        if (alaw_i) begin
            if (top < 5) begin
                sh  = val >> 1;
            end else begin
                seg = 3'(top - 4);
                sh  = val >> (top - 4);
            end
            mant   = sh[3:0];
            code_o = {~neg, seg, mant} ^ A_TOGGLE;
        end else begin
            seg    = 3'(top - 5);
            sh     = val >> (top - 4);
            mant   = sh[3:0];
            code_o = {~neg, ~seg, ~mant};
        end
    end

endmodule

// File: rtl/pcm_pad_mute.sv
module pcm_pad_mute
    import pcm_pad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [BYTE_W-1:0] pcm_in,
    input  logic              sel_pad,
    input  logic              sel_alaw,
    input  logic              atten_en,
    input  logic              thru,
    output logic [BYTE_W-1:0] pcm_out,
    output logic              out_vld
);
    stage_e st_q, st_d;

    logic [BYTE_W-1:0]       cap_byte;
    logic                    cap_pad, cap_alaw, cap_en, cap_thru;
    logic signed [LIN_W-1:0] lin_q;
    logic signed [LIN_W-1:0] lin_exp;
    logic [BYTE_W-1:0]       pack_code;
    logic [BYTE_W-1:0]       pick;

    law_expander #(.LW(LIN_W)) u_exp (
        .code_i (cap_byte),
        .alaw_i (cap_alaw),
        .lin_o  (lin_exp)
    );

    law_compressor #(.LW(LIN_W)) u_cmp (
        .lin_i  (lin_q),
        .alaw_i (cap_alaw),
        .code_o (pack_code)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (frame_stb) st_d = S_EXPAND;   // CAPTURE
            S_EXPAND: st_d = S_SCALE;                   // LINEARIZE
            S_SCALE:  st_d = S_EMIT;                    // ATTENUATE
            S_EMIT:   st_d = S_IDLE;                    // PUBLISH
            default:  st_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // result selection
    always_comb begin
        if (cap_thru || !cap_en) pick = cap_byte;
        else if (!cap_pad)       pick = idle_code(cap_alaw);
        else                     pick = pack_code;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_byte <= '0;
            cap_pad  <= 1'b0;
            cap_alaw <= 1'b0;
            cap_en   <= 1'b0;
            cap_thru <= 1'b0;
            lin_q    <= '0;
            pcm_out  <= '0;
            out_vld  <= 1'b0;
        end else begin
            out_vld <= (st_q == S_EMIT);
            unique case (st_q)
                S_IDLE: begin
                    if (frame_stb) begin
                        cap_byte <= pcm_in;
                        cap_pad  <= sel_pad;
                        cap_alaw <= sel_alaw;
                        cap_en   <= atten_en;
                        cap_thru <= thru;
                    end
                end
                S_EXPAND: lin_q   <= lin_exp;
                S_SCALE:  lin_q   <= lin_q >>> SHIFT;
                S_EMIT:   pcm_out <= pick;
                default:  ;
            endcase
        end
    end

    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && frame_stb) |-> ##4 out_vld);  // R2
    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld);  // R2
    AST_BUSY_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_IDLE) |=> (st_q != S_EXPAND));  // R3
    AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !$past(thru, 4) && !$past(atten_en, 4)) |-> pcm_out == $past(pcm_in, 4));  // R4
    AST_SILENCE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !$past(thru, 4) && $past(atten_en, 4) && !$past(sel_pad, 4))
        |-> pcm_out == ($past(sel_alaw, 4) ? A_IDLE : MU_IDLE));  // R5
    AST_THRU_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(thru, 4)) |-> pcm_out == $past(pcm_in, 4));  // R8
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> $stable(pcm_out));  // R10

endmodule

// File: tb/sim_pcm_pad_mute.sv
`timescale 1ns/1ps
module sim_pcm_pad_mute;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic [7:0] pcm_in = 8'h00;
    logic       sel_pad = 1'b0, sel_alaw = 1'b0, atten_en = 1'b0, thru = 1'b0;
    logic [7:0] pcm_out;
    logic       out_vld;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    pcm_pad_mute u0 (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .pcm_in(pcm_in),
        .sel_pad(sel_pad), .sel_alaw(sel_alaw), .atten_en(atten_en), .thru(thru),
        .pcm_out(pcm_out), .out_vld(out_vld)
    );

    function automatic int mu_value(input logic [7:0] c);
        int s, m, mag;
        s   = (~c >> 4) & 7;
        m   = (~c) & 15;
        mag = (2 * m + 33) * (1 << s) - 33;
        return c[7] ? mag : -mag;
    endfunction

    function automatic int a_value(input logic [7:0] c);
        logic [7:0] t;
        int s, m, mag;
        t   = c ^ 8'h55;
        s   = t[6:4];
        m   = t[3:0];
        mag = (s == 0) ? 2 * m + 1 : (2 * m + 33) * (1 << (s - 1));
        return t[7] ? mag : -mag;
    endfunction

    function automatic logic [7:0] mu_code(input int x);
        int mag, best, lo;
        mag  = (x < 0) ? -x : x;
        if (mag > 8158) mag = 8158;
        best = 0;
        for (int k = 0; k < 128; k++) begin
            lo = (16 + (k & 15)) * (1 << ((k >> 4) + 1)) - 33;
            if (lo <= mag) best = k;
        end
        return {(x >= 0), ~best[6:0]};
    endfunction

    function automatic logic [7:0] a_code(input int x);
        int p, best, lo;
        p    = (x < 0) ? -x - 1 : x;
        if (p > 4095) p = 4095;
        best = 0;
        for (int k = 0; k < 128; k++) begin
            lo = ((k >> 4) == 0) ? 2 * (k & 15) : (16 + (k & 15)) * (1 << (k >> 4));
            if (lo <= p) best = k;
        end
        return {(x >= 0), best[6:0]} ^ 8'h55;
    endfunction

    function automatic logic [7:0] model(input logic [7:0] b, input logic p, input logic a,
                                         input logic e, input logic t);
        if (t || !e) return b;
        if (!p)      return a ? 8'hD5 : 8'hFF;
        if (a)       return a_code(a_value(b) >>> 2);
        return mu_code(mu_value(b) >>> 2);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Drive one sample at a falling edge; result is sampled after edge 3 following acceptance.
    task automatic run_one(input logic [7:0] b, input logic p, input logic a, input logic e,
                           input logic t, input string tag, input bit scramble);
        logic [7:0] exp;
        exp = model(b, p, a, e, t);
        pcm_in = b; sel_pad = p; sel_alaw = a; atten_en = e; thru = t; frame_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R2 pulse dropped", {7'd0, out_vld}, 8'd0);
        frame_stb = 1'b0;
        if (scramble) begin
            pcm_in = ~b; sel_pad = ~p; sel_alaw = ~a; atten_en = ~e; thru = ~t;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 valid due", {7'd0, out_vld}, 8'd1);
        check(tag, pcm_out, exp);
    endtask

    initial begin
        int seed_v;
        int pulses;
        logic [7:0] first;
        seed_v = $urandom(32'd2468);
        repeat (3) @(negedge clk);
        check("R1 reset vld", {7'd0, out_vld}, 8'd0);
        check("R1 reset data", pcm_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 post-reset vld", {7'd0, out_vld}, 8'd0);

        // R4 plain pass, both laws
        run_one(8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, "R4 pass mu", 1'b0);
        run_one(8'h81, 1'b0, 1'b1, 1'b0, 1'b0, "R4 pass A", 1'b0);
        // R5 silence
        run_one(8'h12, 1'b0, 1'b0, 1'b1, 1'b0, "R5 idle mu", 1'b0);
        run_one(8'h12, 1'b0, 1'b1, 1'b1, 1'b0, "R5 idle A", 1'b0);
        run_one(8'h80, 1'b0, 1'b0, 1'b1, 1'b0, "R5 idle mu peak", 1'b0);
        // R8 through overrides everything
        run_one(8'hA7, 1'b1, 1'b0, 1'b1, 1'b1, "R8 thru pad mu", 1'b0);
        run_one(8'h00, 1'b0, 1'b1, 1'b1, 1'b1, "R8 thru mute A", 1'b0);
        // R6 / R7 corner codes
        run_one(8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, "R6 mu zero", 1'b0);
        run_one(8'h80, 1'b1, 1'b0, 1'b1, 1'b0, "R6 mu max pos", 1'b0);
        run_one(8'h00, 1'b1, 1'b0, 1'b1, 1'b0, "R6 mu max neg", 1'b0);
        run_one(8'hD5, 1'b1, 1'b1, 1'b1, 1'b0, "R7 A smallest pos", 1'b0);
        run_one(8'h2A, 1'b1, 1'b1, 1'b1, 1'b0, "R7 A max neg", 1'b0);
        // R6 / R7 every code
        for (int c = 0; c < 256; c++) run_one(8'(c), 1'b1, 1'b0, 1'b1, 1'b0, "R6 mu sweep", 1'b0);
        for (int c = 0; c < 256; c++) run_one(8'(c), 1'b1, 1'b1, 1'b1, 1'b0, "R7 A sweep", 1'b0);
        // R9 settings taken at strobe only
        run_one(8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, "R9 late change pad mu", 1'b1);
        run_one(8'h5A, 1'b0, 1'b1, 1'b1, 1'b0, "R9 late change mute A", 1'b1);
        run_one(8'h5A, 1'b1, 1'b1, 1'b0, 1'b1, "R9 late change thru", 1'b1);

        // R3 strobe held through the busy window
        first = 8'h9B;
        pcm_in = first; sel_pad = 1'b1; sel_alaw = 1'b0; atten_en = 1'b1; thru = 1'b0;
        frame_stb = 1'b1;
        @(posedge clk);
        @(negedge clk); pcm_in = 8'h11;
        @(posedge clk);
        @(negedge clk); pcm_in = 8'h22;
        @(posedge clk);
        @(negedge clk); pcm_in = 8'h33;
        @(posedge clk);
        @(negedge clk);
        frame_stb = 1'b0;
        check("R3 first pulse", {7'd0, out_vld}, 8'd1);
        check("R3 captured byte", pcm_out, model(first, 1'b1, 1'b0, 1'b1, 1'b0));
        pulses = 0;
        repeat (8) begin
            @(negedge clk);
            if (out_vld) pulses++;
        end
        check("R3 no extra pulse", 8'(pulses), 8'd0);
        check("R10 held", pcm_out, model(first, 1'b1, 1'b0, 1'b1, 1'b0));

        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [7:0] rb;
            logic [3:0] rc;
            rb = 8'($urandom);
            rc = 4'($urandom);
            run_one(rb, rc[0], rc[1], rc[2], (rc[3] && rb[0]), "R4-R8 random mix", 1'b0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule